// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status

This block watches eight general-purpose input pins and turns their activity into one interrupt request for the port. Each pin has its own sense setting. The setting picks level or edge detection, the active polarity, and whether one edge or both edges count. A detected event sets that pin's bit in a status register. Software acknowledges an event by writing ones to a write-one-to-clear address. A per-pin enable register decides which status bits can raise the request.

Each pin input is synchronized before detection. Edge detection compares the synchronized value with its value one cycle earlier. For an edge-mode pin, the status bit stays set until software clears it. If an edge arrives in the same cycle as its clear, the edge wins, so an edge that occurs during service is not lost. For a level-mode pin, the status bit follows the active level on every cycle, and a clear has no effect while the level persists.

Configuration uses a simple write strobe and a combinational read port. The sense, enable and status registers each have a second, masked address. A write there changes only the pins selected by its mask bits.

Top module: `gpio_irq_sense`

## Requirements
- R1: While reset is held, status, enable and sense configuration all read 0 and `irq_o` is low.
- R2: The sense register at offset 0x60 holds, for pin n: polarity in bit n, edge mode in bit 8+n, and both-edges in bit 16+n. The five encodings (per pin, before the shift) are:
  - rising edge = 0x000101
  - falling edge = 0x000100
  - both edges = 0x010100
  - level high = 0x000001
  - level low = 0x000000
- R3: A pin set to rising edge sets its status bit on a 0-to-1 change of its input. The bit reads set on the third rising clock edge after the input changes, and not on the second.
- R4: A pin set to falling edge sets its status bit only on a 1-to-0 change.
- R5: A pin set to both edges sets its status bit on either change.
- R6: A level-mode pin's status bit is 1 exactly while its input is at the active level (high for level high, low for level low). Writing a clear for it while the level is active leaves the bit at 1.
- R7: Writing to offset 0x70 clears the status bit of each edge-mode pin whose data bit is 1. Data bits that are 0 change nothing.
- R8: `irq_o` is 1 exactly when some pin has both its status bit (offset 0x40) and its enable bit (offset 0x50) at 1.
- R9: The masked addresses are the base offsets plus 0x80.
  - For status and enable, bits 15:8 select the pins and bits 7:0 give their new values.
  - A masked status write sets or clears an edge-mode pin's bit.
  - For sense, bits 31:24 select the pins, and each selected pin takes its bits n, 8+n and 16+n from the data.
- R10: When an edge and a clear for the same pin fall in the same cycle, the status bit ends up set.
- R11: A write to the plain status address 0x40 has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq_o | output | 1 | Port interrupt request |

## Verification
The bench lands a CLR write on exactly the cycle in which a rising edge is detected. A design that gives the clear priority would drop that edge and read status 0 instead of 1. It also clears a level-high pin while the level is still active; a design that treats level pins like edge pins would wrongly read that bit as 0. The masked sense and enable writes are checked against their neighbouring pins, which catches a mask that is ignored or shifted. The bench also samples status one edge too early after an input change, which exposes a missing or extra synchronizer stage.

// File: rtl/gsense_pkg.sv
package gsense_pkg;

  // register byte offsets (plain aliases)
  localparam int OFS_STA = 'h40;
  localparam int OFS_ENB = 'h50;
  localparam int OFS_LVL = 'h60;
  localparam int OFS_CLR = 'h70;

  // byte lanes of the sense register
  localparam int LANE_POL  = 0;
  localparam int LANE_EDGE = 8;
  localparam int LANE_BOTH = 16;
  localparam int LANE_LMSK = 24;

  // single-pin edge event under the pin's sense setting
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic pol, input logic both);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return both ? (rise | fall) : (pol ? rise : fall);
  endfunction

  // single-pin level condition under the pin's polarity
  function automatic logic level_active(input logic cur, input logic pol);
    return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/gsense_sync.sv
module gsense_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_cur,
  output logic [W-1:0] q_prev
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      hist_q  <= '0;
    end else begin
      chain_q[0] <= d;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      hist_q <= chain_q[STAGES-1];
    end
  end

  assign q_cur  = chain_q[STAGES-1];
  assign q_prev = hist_q;

endmodule

// File: rtl/gsense_cell.sv
module gsense_cell
  import gsense_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic pol,
  input  logic edg,
  input  logic both,
  input  logic clr_i,
  input  logic set_i,
  output logic sta_o,
  output logic hit_o,
  output logic lvl_on_o
);

  assign hit_o    = edge_hit(cur, prev, pol, both);
  assign lvl_on_o = level_active(cur, pol);

  always_ff @(posedge clk) begin
    if (rst)      sta_o <= 1'b0;
    else if (edg) sta_o <= hit_o | set_i | (sta_o & ~clr_i);
    else          sta_o <= lvl_on_o;
  end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gsense_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2,
  parameter int UPPER_OFS   = 'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic             irq_o
);

  localparam logic [AW-1:0] A_STA  = AW'(OFS_STA);
  localparam logic [AW-1:0] A_ENB  = AW'(OFS_ENB);
  localparam logic [AW-1:0] A_LVL  = AW'(OFS_LVL);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_MSTA = AW'(OFS_STA + UPPER_OFS);
  localparam logic [AW-1:0] A_MENB = AW'(OFS_ENB + UPPER_OFS);
  localparam logic [AW-1:0] A_MLVL = AW'(OFS_LVL + UPPER_OFS);

  function automatic logic [NPINS-1:0] merge_bits(input logic [NPINS-1:0] old_v,
                                                  input logic [NPINS-1:0] val,
                                                  input logic [NPINS-1:0] sel);
    return (old_v & ~sel) | (val & sel);
  endfunction

  logic [NPINS-1:0] enb_q, pol_q, edg_q, both_q;
  logic [NPINS-1:0] sta_q, hit_vec, lvl_on_vec, clr_vec, set_vec;
  logic [NPINS-1:0] cur_s, prev_s;
  logic [NPINS-1:0] d_lo, d_mid, d_hi, d_top;

  // named write strobes
  logic wr_enb, wr_menb, wr_lvl, wr_mlvl, wr_clr, wr_msta;

  assign wr_enb  = wr_en && (wr_addr == A_ENB);
  assign wr_menb = wr_en && (wr_addr == A_MENB);
  assign wr_lvl  = wr_en && (wr_addr == A_LVL);
  assign wr_mlvl = wr_en && (wr_addr == A_MLVL);
  assign wr_clr  = wr_en && (wr_addr == A_CLR);
  assign wr_msta = wr_en && (wr_addr == A_MSTA);

  assign d_lo  = wr_data[LANE_POL  +: NPINS];
  assign d_mid = wr_data[LANE_EDGE +: NPINS];
  assign d_hi  = wr_data[LANE_BOTH +: NPINS];
  assign d_top = wr_data[LANE_LMSK +: NPINS];

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      enb_q  <= '0;
      pol_q  <= '0;
      edg_q  <= '0;
      both_q <= '0;
    end else begin
      if (wr_enb)       enb_q <= d_lo;
      else if (wr_menb) enb_q <= merge_bits(enb_q, d_lo, d_mid);

      if (wr_lvl) begin
        pol_q  <= d_lo;
        edg_q  <= d_mid;
        both_q <= d_hi;
      end else if (wr_mlvl) begin
        pol_q  <= merge_bits(pol_q,  d_lo,  d_top);
        edg_q  <= merge_bits(edg_q,  d_mid, d_top);
        both_q <= merge_bits(both_q, d_hi,  d_top);
      end
    end
  end

  // acknowledge and software set paths
  assign clr_vec = ({NPINS{wr_clr}} & d_lo) | ({NPINS{wr_msta}} & d_mid & ~d_lo);
  assign set_vec = {NPINS{wr_msta}} & d_mid & d_lo;

  gsense_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      (pins_i),
    .q_cur  (cur_s),
    .q_prev (prev_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gsense_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .cur      (cur_s[i]),
      .prev     (prev_s[i]),
      .pol      (pol_q[i]),
      .edg      (edg_q[i]),
      .both     (both_q[i]),
      .clr_i    (clr_vec[i]),
      .set_i    (set_vec[i]),
      .sta_o    (sta_q[i]),
      .hit_o    (hit_vec[i]),
      .lvl_on_o (lvl_on_vec[i])
    );
  end

  assign irq_o = |(sta_q & enb_q);

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STA, A_MSTA: rd_data[LANE_POL +: NPINS] = sta_q;
      A_ENB, A_MENB: rd_data[LANE_POL +: NPINS] = enb_q;
      A_LVL, A_MLVL: begin
        rd_data[LANE_POL  +: NPINS] = pol_q;
        rd_data[LANE_EDGE +: NPINS] = edg_q;
        rd_data[LANE_BOTH +: NPINS] = both_q;
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gsense_chk.sv
module gsense_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] sta,
  input logic [NPINS-1:0] enb,
  input logic [NPINS-1:0] edge_mask,
  input logic [NPINS-1:0] hit_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] set_vec,
  input logic [NPINS-1:0] lvl_on_vec,
  input logic             irq
);

  // R1
  enb_reset_chk: assert property (@(posedge clk) rst |=> (enb == '0));

  // R8
  irq_needs_enb_chk: assert property (@(posedge clk) disable iff (rst)
    (enb == '0) |-> !irq);

  // R8
  irq_needs_sta_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sta != '0));

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sta & $past(hit_vec & edge_mask)) == $past(hit_vec & edge_mask)));

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sta & $past(clr_vec & ~hit_vec & ~set_vec & edge_mask)) == '0));

  // R6
  level_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((sta ^ $past(lvl_on_vec)) & $past(~edge_mask)) == '0));

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sta & ~$past(sta) & $past(edge_mask & ~hit_vec & ~set_vec)) == '0));

endmodule

bind gpio_irq_sense gsense_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sta        (sta_q),
  .enb        (enb_q),
  .edge_mask  (edg_q),
  .hit_vec    (hit_vec),
  .clr_vec    (clr_vec),
  .set_vec    (set_vec),
  .lvl_on_vec (lvl_on_vec),
  .irq        (irq_o)
);

// File: tb/gpio_irq_sense_test.sv
`timescale 1ns/1ps
module gpio_irq_sense_test;

  localparam logic [11:0] A_STA  = 12'h040;
  localparam logic [11:0] A_ENB  = 12'h050;
  localparam logic [11:0] A_LVL  = 12'h060;
  localparam logic [11:0] A_CLR  = 12'h070;
  localparam logic [11:0] A_MSTA = 12'h0C0;
  localparam logic [11:0] A_MENB = 12'h0D0;
  localparam logic [11:0] A_MLVL = 12'h0E0;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = 8'h00;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_irq_sense uut (
    .clk     (clk),
    .rst     (rst),
    .pins_i  (pins),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_o   (irq_o)
  );

  // monitor: pop expected items and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_tests++;
        if (rd_data !== it.data || irq_o !== it.irq) begin
          n_fail++;
          $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                   it.tag, rd_data, irq_o, it.data, it.irq);
        end
      end
    end
  end

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] d,
                        input logic q, input string tag);
    @(posedge clk);
    #1;
    rd_addr = a;
    sb_q.push_back('{d, q, tag});
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk);
    #1;
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic drive_pin(input int i, input logic v, input int edges);
    @(posedge clk);
    #1;
    pins[i] = v;
    repeat (edges) @(posedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(WATCHDOG_CYCLES * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1 reset state
    exp_rd(A_STA, 32'h0, 1'b0, "R1 status in reset");
    exp_rd(A_ENB, 32'h0, 1'b0, "R1 enable in reset");
    exp_rd(A_LVL, 32'h0, 1'b0, "R1 sense in reset");
    @(posedge clk);
    #1;
    rst = 1'b0;
    repeat (4) @(posedge clk);
    // R6 level low is the reset sense; all pins low
    exp_rd(A_STA, 32'h0000_00FF, 1'b0, "R6 level low after reset");

    // R2 all pins rising edge
    wr(A_LVL, 32'h0000_FFFF);
    exp_rd(A_LVL, 32'h0000_FFFF, 1'b0, "R2 sense write readback");
    wr(A_CLR, 32'h0000_00FF);
    exp_rd(A_STA, 32'h0, 1'b0, "R7 clear all");

    // R3 rising edge with latency
    drive_pin(0, 1'b1, 1);
    exp_rd(A_STA, 32'h0, 1'b0, "R3 not set after two edges");
    exp_rd(A_STA, 32'h01, 1'b0, "R3 set after three edges");
    wr(A_CLR, 32'h0);
    exp_rd(A_STA, 32'h01, 1'b0, "R7 zero write no effect");

    // R8 enable gating
    wr(A_ENB, 32'h01);
    exp_rd(A_ENB, 32'h01, 1'b1, "R8 enabled pending raises irq");
    wr(A_ENB, 32'h02);
    exp_rd(A_ENB, 32'h02, 1'b0, "R8 masked pending no irq");

    drive_pin(0, 1'b0, 2);
    exp_rd(A_STA, 32'h01, 1'b0, "R3 falling ignored on rising pin");
    wr(A_CLR, 32'h01);
    exp_rd(A_STA, 32'h0, 1'b0, "R7 clear pin0");

    // R4 falling edge on pin1 via masked sense write
    wr(A_MLVL, 32'h0200_0200);
    exp_rd(A_LVL, 32'h0000_FFFD, 1'b0, "R9 masked sense pin1");
    drive_pin(1, 1'b1, 2);
    exp_rd(A_STA, 32'h0, 1'b0, "R4 rise ignored on falling pin");
    drive_pin(1, 1'b0, 2);
    exp_rd(A_STA, 32'h02, 1'b1, "R4 falling sets status");
    wr(A_CLR, 32'h02);
    exp_rd(A_STA, 32'h0, 1'b0, "R7 clear pin1");

    // R5 both edges on pin2
    wr(A_MLVL, 32'h0404_0400);
    exp_rd(A_LVL, 32'h0004_FFF9, 1'b0, "R9 masked sense pin2");
    drive_pin(2, 1'b1, 2);
    exp_rd(A_STA, 32'h04, 1'b0, "R5 rise sets");
    wr(A_CLR, 32'h04);
    exp_rd(A_STA, 32'h0, 1'b0, "R7 clear pin2");
    drive_pin(2, 1'b0, 2);
    exp_rd(A_STA, 32'h04, 1'b0, "R5 fall sets");
    wr(A_CLR, 32'h04);

    // R6 level high on pin3
    wr(A_MLVL, 32'h0800_0008);
    exp_rd(A_LVL, 32'h0004_F7F9, 1'b0, "R2 level high encoding");
    exp_rd(A_STA, 32'h0, 1'b0, "R6 level high inactive");
    drive_pin(3, 1'b1, 2);
    exp_rd(A_STA, 32'h08, 1'b0, "R6 level high active");
    wr(A_CLR, 32'h08);
    exp_rd(A_STA, 32'h08, 1'b0, "R6 clear ignored while active");
    drive_pin(3, 1'b0, 2);
    exp_rd(A_STA, 32'h0, 1'b0, "R6 level high released");

    // R6 level low on pin4
    wr(A_MLVL, 32'h1000_0000);
    exp_rd(A_STA, 32'h10, 1'b0, "R6 level low active");
    drive_pin(4, 1'b1, 2);
    exp_rd(A_STA, 32'h0, 1'b0, "R6 level low released");

    // R9 masked enable
    wr(A_MENB, 32'h1010);
    exp_rd(A_ENB, 32'h12, 1'b0, "R9 masked enable set");
    wr(A_MENB, 32'h0200);
    exp_rd(A_ENB, 32'h10, 1'b0, "R9 masked enable clear");
    drive_pin(4, 1'b0, 2);
    exp_rd(A_STA, 32'h10, 1'b1, "R8 level pin raises irq");
    drive_pin(4, 1'b1, 2);
    exp_rd(A_STA, 32'h0, 1'b0, "R8 irq drops with level");

    // R9 masked status set and clear
    wr(A_MSTA, 32'h2020);
    exp_rd(A_STA, 32'h20, 1'b0, "R9 masked status set");
    wr(A_MSTA, 32'h2000);
    exp_rd(A_STA, 32'h0, 1'b0, "R9 masked status clear");

    // R11 plain status write ignored
    wr(A_STA, 32'h0000_00FF);
    exp_rd(A_STA, 32'h0, 1'b0, "R11 plain status write");

    // R10 edge and clear in the same cycle
    @(posedge clk);
    #1;
    pins[6] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    wr_en   = 1'b1;
    wr_addr = A_CLR;
    wr_data = 32'h40;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    exp_rd(A_STA, 32'h40, 1'b0, "R10 edge beats clear");
    wr(A_CLR, 32'h40);
    exp_rd(A_STA, 32'h0, 1'b0, "R7 clear pin6");

    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule